// File: doc/BRIEF.md
# ADC Conversion Sequencer with Shadowed Channel Selection

This block is the digital controller of a 10-bit successive-approximation converter. Software writes a combined channel and reference code into a staging register whenever it likes. An active copy of that code drives the analog input mux. The active copy tracks the staging register while the sequencer is between conversions. It stays frozen from the moment a conversion begins until the completion window, so the sampled channel cannot change under the converter.

The sequencer runs from a clock at twice the converter clock rate. A phase bit marks the high half (`adc_clk` = 1) and the low half of each converter clock, which lets events at half-cycle positions land exactly. A conversion is requested by a software start strobe or, in auto mode, by a trigger pulse. It begins on the next high half of the converter clock. The block emits a one-cycle sample-and-hold strobe and walks a trial code from MSB to LSB. Each trial code is resolved by the external comparator bit `cmp_in`. The final code is published together with a completion pulse and a sticky flag.

The state machine has five states. IDLE waits for a request. ARM waits for the next converter rising edge. ACQ is the acquisition window that ends with the hold strobe. CONV holds the ten bit decisions. CMPL is the completion window of one converter clock. The transitions are:
- IDLE→ARM on an accepted request.
- ARM→ACQ when the next cycle is a high half.
- ACQ→CONV at the hold point.
- CONV→CMPL after the last decision.
- CMPL→IDLE after two cycles.
- Any state→IDLE when `en` is low (abort).

Top module: `adc_seq_ctrl`

## Requirements
- R1: While the sequencer is in IDLE or ARM, `sel_active` equals the value written through `sel_wr`/`sel_wdata`, two clock cycles after the write cycle.
- R2: From the first ACQ cycle until the first CMPL cycle, `sel_active` does not change, even if `sel_wr` is used. Tracking resumes inside CMPL, so a value written during a conversion is visible once the sequencer is back in IDLE.
- R3: An accepted request makes `busy` high in the next cycle. The conversion's first ACQ cycle is the first cycle with `adc_clk` = 1 that comes after the ARM state. This is request cycle + 2 if `adc_clk` was 1 in the request cycle, and request cycle + 3 otherwise.
- R4: The hold strobe comes a number of half-cycles after the conversion start that depends on the kind of conversion: 27 for the first conversion after reset or re-enable, 3 for a start strobe, and 4 for an auto trigger. Completion starts 21 cycles after the hold strobe. The sequencer is back in IDLE 23 cycles after the hold strobe, which gives totals of 25, 13 and 13.5 converter clocks.
- R5: The trial code `sar_trial` starts at 0x200, and bits are decided from MSB to LSB. A bit is kept when `cmp_in` = 1. With an ideal comparator on input level v, `result` equals min(v, 1023).
- R6: `conv_done` is high for exactly two cycles (one converter clock). `result` takes its new value in the first of those cycles and changes at no other time.
- R7: `cmpl_flag` rises with `conv_done` and stays high until a cycle with `flag_clr` = 1. A completion in the same cycle as `flag_clr` wins over the clear.
- R8: Start strobes and triggers that arrive while `busy` is high are ignored. No second conversion follows.
- R9: `trig_pulse` is accepted only when `auto_mode` = 1. A `start_pulse` is always accepted when the sequencer is in IDLE and `en` is high, and it uses start-strobe timing. If both arrive in the same cycle, the start strobe wins.
- R10: `en` = 0 forces IDLE in the next cycle, with no completion pulse, and blocks new requests. The next conversion after re-enable uses first-conversion timing.
- R11: While reset is held, `busy`, `conv_done`, `cmpl_flag` and `result` are 0 and `adc_clk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the converter clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable; low aborts and re-arms first-conversion timing |
| auto_mode | input | 1 | Allows `trig_pulse` to start conversions |
| start_pulse | input | 1 | Software start strobe |
| trig_pulse | input | 1 | Auto-trigger pulse |
| sel_wr | input | 1 | Write strobe for the staging selection |
| sel_wdata | input | SEL_W | Channel and reference code to stage |
| flag_clr | input | 1 | Write-one clear of the completion flag |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| adc_clk | output | 1 | Converter clock phase: 1 in the high half |
| sel_active | output | SEL_W | Active selection driving the mux and reference |
| sh_hold | output | 1 | One-cycle sample-and-hold strobe |
| sar_trial | output | RES_W | Trial code presented to the DAC |
| busy | output | 1 | Sequencer is not in IDLE |
| conv_done | output | 1 | Completion window, one converter clock long |
| cmpl_flag | output | 1 | Sticky completion flag |
| result | output | RES_W | Last conversion result |

## Verification
The hardest case to reach is a staging write that lands inside a running conversion. It must be invisible at the hold strobe and visible after CMPL, and it interacts with the random phase at which the request arrived. The stimulus inserts a random number of idle cycles before each request, so requests arrive in both halves of the converter clock. It writes a new selection one cycle after the conversion starts, and checks the frozen and resumed values at cycle positions that the bench computes from the kind of conversion. Aborts are reached by dropping `en` in the middle of CONV, followed by a restart that must show first-conversion timing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_ACQ,
        ST_CONV,
        ST_CMPL
    } seq_state_t;
endpackage

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    input  logic             track,
    output logic [SEL_W-1:0] active
);
    logic [SEL_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr) begin
            stage_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (track) begin
            active <= stage_q;
        end
    end

    AST_SEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        track |=> (active == $past(stage_q))); // R1
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !track |=> $stable(active)); // R2
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             decide,
    input  logic             finish,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] mask_q;

    assign trial = acc_q | mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            mask_q <= TOP_BIT;
        end else if (init) begin
            acc_q  <= '0;
            mask_q <= TOP_BIT;
        end else if (decide) begin
            if (cmp_in) begin
                acc_q <= acc_q | mask_q;
            end
            mask_q <= mask_q >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (finish) begin
            result <= cmp_in ? (acc_q | mask_q) : acc_q;
        end
    end

    AST_TRIAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && cmp_in) |=> ((trial & $past(mask_q)) != '0)); // R5
    AST_TRIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !cmp_in) |=> ((trial & $past(mask_q)) == '0)); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(result)); // R6
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int SEL_W      = 7,
    parameter int HOLD_FIRST = 27,
    parameter int HOLD_NORM  = 3,
    parameter int HOLD_AUTO  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             auto_mode,
    input  logic             start_pulse,
    input  logic             trig_pulse,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             flag_clr,
    input  logic             cmp_in,
    output logic             adc_clk,
    output logic [SEL_W-1:0] sel_active,
    output logic             sh_hold,
    output logic [RES_W-1:0] sar_trial,
    output logic             busy,
    output logic             conv_done,
    output logic             cmpl_flag,
    output logic [RES_W-1:0] result
);
    localparam int CONV_SPAN = 2 * RES_W;
    localparam int CNT_W     = $clog2(HOLD_FIRST + CONV_SPAN + 4);

    seq_state_t       st, nxt;
    logic             ph;
    logic             first_pend;
    logic [CNT_W-1:0] h;
    logic [CNT_W-1:0] hold_r;
    logic [CNT_W-1:0] rel;
    logic             start_req;
    logic             last_dec;
    logic             track;
    logic             sar_init;
    logic             sar_dec;
    logic             sar_fin;

    assign start_req = en && (start_pulse || (auto_mode && trig_pulse));
    assign rel       = h - hold_r;
    assign last_dec  = (st == ST_CONV) && (rel == CNT_W'(CONV_SPAN));
    assign adc_clk   = ~ph;

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (start_req) nxt = ST_ARM;
            ST_ARM:  if (ph) nxt = ST_ACQ;
            ST_ACQ:  if (h == hold_r) nxt = ST_CONV;
            ST_CONV: if (last_dec) nxt = ST_CMPL;
            ST_CMPL: if (rel == CNT_W'(CONV_SPAN + 2)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Phase, position counter, conversion kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= 1'b0;
            h          <= '0;
            hold_r     <= CNT_W'(HOLD_FIRST);
            first_pend <= 1'b1;
        end else begin
            ph <= ~ph;
            if (st == ST_IDLE || st == ST_ARM) h <= '0;
            else                               h <= h + 1'b1;
            if (st == ST_IDLE && start_req) begin
                if (first_pend)       hold_r <= CNT_W'(HOLD_FIRST);
                else if (start_pulse) hold_r <= CNT_W'(HOLD_NORM);
                else                  hold_r <= CNT_W'(HOLD_AUTO);
            end
            if (!en)                           first_pend <= 1'b1;
            else if (st == ST_ARM && ph)       first_pend <= 1'b0;
        end
    end

    // Completion flag
    always_ff @(posedge clk) begin
        if (!rst_n)                        cmpl_flag <= 1'b0;
        else if (last_dec && en)           cmpl_flag <= 1'b1;
        else if (flag_clr)                 cmpl_flag <= 1'b0;
    end

    // Moore outputs
    always_comb begin
        busy      = (st != ST_IDLE);
        conv_done = (st == ST_CMPL);
        sh_hold   = (st == ST_ACQ) && (h == hold_r);
        track     = (st == ST_IDLE) || (st == ST_ARM) || (st == ST_CMPL);
        sar_init  = (st == ST_ARM);
        sar_dec   = (st == ST_CONV) && !rel[0];
        sar_fin   = last_dec && en;
    end

    adc_sel_shadow #(.SEL_W(SEL_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (sel_wr),
        .wdata  (sel_wdata),
        .track  (track),
        .active (sel_active)
    );

    adc_sar_reg #(.RES_W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (sar_init),
        .decide (sar_dec),
        .finish (sar_fin),
        .cmp_in (cmp_in),
        .trial  (sar_trial),
        .result (result)
    );

    AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACQ && h == '0) |-> adc_clk); // R3
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy); // R10
    AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_done) |=> conv_done); // R6
    AST_DONE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && $past(conv_done)) |=> !conv_done); // R6
    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_done) |-> cmpl_flag); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done && en) |=> busy); // R8
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W = 10;
    localparam int SEL_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             auto_mode = 1'b0;
    logic             start_pulse = 1'b0;
    logic             trig_pulse = 1'b0;
    logic             sel_wr = 1'b0;
    logic [SEL_W-1:0] sel_wdata = '0;
    logic             flag_clr = 1'b0;
    logic             cmp_in = 1'b0;
    logic             adc_clk;
    logic [SEL_W-1:0] sel_active;
    logic             sh_hold;
    logic [RES_W-1:0] sar_trial;
    logic             busy;
    logic             conv_done;
    logic             cmpl_flag;
    logic [RES_W-1:0] result;

    int checks = 0;
    int fails = 0;
    int vin_model = 0;

    adc_seq_ctrl #(.RES_W(RES_W), .SEL_W(SEL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .auto_mode(auto_mode),
        .start_pulse(start_pulse), .trig_pulse(trig_pulse),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .flag_clr(flag_clr),
        .cmp_in(cmp_in), .adc_clk(adc_clk), .sel_active(sel_active),
        .sh_hold(sh_hold), .sar_trial(sar_trial), .busy(busy),
        .conv_done(conv_done), .cmpl_flag(cmpl_flag), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal comparator model
    always @(negedge clk) cmp_in = (vin_model >= int'(sar_trial));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_hold(input int kind);
        if (kind == 0) return 27;
        if (kind == 1) return 3;
        return 4;
    endfunction

    function automatic int exp_res(input int v);
        return (v > 1023) ? 1023 : v;
    endfunction

    // kind: 0 first, 1 start strobe, 2 trigger. act: 0 none, 1 extra start, 2 staging write
    task automatic run_conv(input int kind, input bit use_trig, input int v,
                            input int act, input logic [SEL_W-1:0] new_sel);
        int p, s, hh, hk, dk, ik, dlen;
        logic [SEL_W-1:0] old_sel;
        @(negedge clk);
        p = adc_clk ? 0 : 1;
        s = (p == 0) ? 2 : 3;
        hh = exp_hold(kind);
        vin_model = v;
        old_sel = sel_active;
        if (use_trig) trig_pulse = 1'b1; else start_pulse = 1'b1;
        hk = -1; dk = -1; ik = -1; dlen = 0;
        for (int k = 1; k <= 120; k++) begin
            @(negedge clk);
            start_pulse = 1'b0; trig_pulse = 1'b0; sel_wr = 1'b0;
            if (k == 1) chk(busy == 1'b1, "R3 busy after request", int'(busy), 1);
            if (sh_hold && hk < 0) begin
                hk = k;
                chk(sel_active == old_sel, "R2 frozen at hold", int'(sel_active), int'(old_sel));
            end
            if (conv_done) begin
                if (dk < 0) begin
                    dk = k;
                    chk(int'(result) == exp_res(v), "R5 result", int'(result), exp_res(v));
                    chk(cmpl_flag == 1'b1, "R7 flag with done", int'(cmpl_flag), 1);
                end
                dlen++;
            end
            if (!busy) begin
                ik = k;
                break;
            end
            if (act == 2 && k == s + 1) begin
                sel_wr = 1'b1;
                sel_wdata = new_sel;
            end
            if (act == 1 && k == s + 6) begin
                start_pulse = 1'b1;
                trig_pulse = auto_mode;
            end
        end
        chk(hk == s + hh, "R4 hold position", hk, s + hh);
        chk(dk == s + hh + 21, "R4 completion position", dk, s + hh + 21);
        chk(ik == s + hh + 23, "R4 return to idle", ik, s + hh + 23);
        chk(dlen == 2, "R6 done length", dlen, 2);
        if (act == 2)
            chk(sel_active == new_sel, "R2 tracking resumed", int'(sel_active), int'(new_sel));
        if (act == 1) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b0, "R8 start during conversion ignored", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11 busy in reset", int'(busy), 0);
        chk(conv_done == 1'b0, "R11 done in reset", int'(conv_done), 0);
        chk(cmpl_flag == 1'b0, "R11 flag in reset", int'(cmpl_flag), 0);
        chk(result == '0, "R11 result in reset", int'(result), 0);
        chk(adc_clk == 1'b1, "R11 phase in reset", int'(adc_clk), 1);
        rst_n = 1'b1;
        en = 1'b1;
        @(negedge clk);

        // R1 tracking while idle
        sel_wr = 1'b1; sel_wdata = 7'h2A;
        @(negedge clk); sel_wr = 1'b0;
        @(negedge clk);
        chk(sel_active == 7'h2A, "R1 follow staging", int'(sel_active), 'h2A);

        // R4 first conversion, with a write during conversion (R2)
        run_conv(0, 1'b0, 700, 2, 7'h15);
        run_conv(1, 1'b0, 0, 0, '0);
        run_conv(1, 1'b0, 1023, 0, '0);
        run_conv(1, 1'b0, 1090, 1, '0);

        // R7 sticky flag and clear
        repeat (3) @(negedge clk);
        chk(cmpl_flag == 1'b1, "R7 flag sticky", int'(cmpl_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(cmpl_flag == 1'b0, "R7 flag cleared", int'(cmpl_flag), 0);

        // R9 trigger ignored without auto mode
        auto_mode = 1'b0; trig_pulse = 1'b1;
        @(negedge clk); trig_pulse = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 trigger ignored", int'(busy), 0);

        // R9 auto mode: trigger timing and start-strobe timing
        auto_mode = 1'b1;
        run_conv(2, 1'b1, 333, 0, '0);
        run_conv(1, 1'b0, 512, 0, '0);
        run_conv(2, 1'b1, 511, 1, '0);

        // R10 abort mid conversion
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        start_pulse = 1'b1; vin_model = 100;
        @(negedge clk); start_pulse = 1'b0;
        repeat (10) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R10 abort to idle", int'(busy), 0);
        start_pulse = 1'b1;
        @(negedge clk); start_pulse = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (conv_done || busy) begin
                chk(1'b0, "R10 no activity while disabled", int'(busy), 0);
                break;
            end
        end
        chk(cmpl_flag == 1'b0, "R10 no flag after abort", int'(cmpl_flag), 0);
        en = 1'b1;
        run_conv(0, 1'b0, 77, 0, '0);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int gap, kind, v, act;
            bit trg;
            gap = int'($urandom % 4);
            repeat (gap) @(negedge clk);
            auto_mode = 1'($urandom % 2);
            trg = auto_mode && ($urandom % 2 == 1);
            kind = trg ? 2 : 1;
            v = int'($urandom % 1100);
            act = int'($urandom % 3);
            if ($urandom % 4 == 0) begin
                flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
            end
            run_conv(kind, trg, v, act, 7'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule